// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns four reset requests into one internal chip reset (`sys_rst`, active high) and a matching active-low reset output (`rst_out_n`). The requests are power-on, an external reset pin, a watchdog timeout and a brown-out detector. All inputs arrive already synchronised to `clk`. Power-on (`por_n`) is also the synchronous reset of the block itself.

While any request is present, reset is held and the wake-up counter is cleared. Once every request has gone, the counter runs, but only in cycles where the oscillator reports ready. Reset is released only when four things hold together: the count has reached `WAKE_CYCLES`, the oscillator is ready, the flash controller reports that its initialisation is done, and, if a brown-out took part in this reset, the supply is reported good again.

In the release cycle the block pulses `boot_go` for one cycle and presents the reset vector on `boot_addr`. A sticky cause register keeps one bit for each source. Software can clear its bits by writing ones.

Top module: `chip_reset_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst`=1 and `rst_out_n`=0. `cause` becomes 4'b0001, which clears every other bit. Cause bit map: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 brown-out.
- R2: If `ext_rst_n`=0, `wdt_req`=1 or `bod_req`=1 at a clock edge, then after that edge `sys_rst`=1 and `rst_out_n`=0.
- R3: Reset is never released while the oscillator is not ready (`osc_ready`=0), even long after the count would have finished.
- R4: With all flags high, reset is released at the (`WAKE_CYCLES`+2)th edge after the last edge that saw a request. The counter holds in cycles where `osc_ready`=0.
- R5: If `flash_init_done` is low after the count is done, reset stays held. It is released at the first edge that sees the flag high.
- R6: After a brown-out request, reset stays held until `vdd_ok`=1. It is released at the first edge that sees `vdd_ok` high once the count is done.
- R7: A request that arrives while the sequencer is waiting clears the count. A full `WAKE_CYCLES`+2 edges are then needed after that request goes away.
- R8: The cause register sets each request's bit and keeps it. While `cause_clr_we`=1, a one in `cause_clr_mask` clears that bit at the edge. A bit that is being set in the same cycle stays set.
- R9: `boot_go` is high for exactly the one cycle that follows the release edge, and `boot_addr` then equals `RESET_VECTOR` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset request, active low; also resets the block |
| ext_rst_n | input | 1 | External reset pin request, active low |
| wdt_req | input | 1 | Watchdog timeout request |
| bod_req | input | 1 | Brown-out detected request |
| vdd_ok | input | 1 | Supply above the brown-out threshold |
| osc_ready | input | 1 | Oscillator running |
| flash_init_done | input | 1 | Flash controller initialisation complete |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 4 | Write-one-to-clear mask for cause bits |
| sys_rst | output | 1 | Internal chip reset, active high, registered |
| rst_out_n | output | 1 | Reset output, active low, registered |
| boot_go | output | 1 | One-cycle pulse when reset is released |
| boot_addr | output | ADDR_W | Fetch address for the core (reset vector) |
| cause | output | 4 | Sticky reset-cause bits |

## Verification
Some behaviours are checked by assertions on every cycle:
- a request forces reset at the next edge;
- a release is only ever preceded by a finished count with the oscillator, flash and pin conditions true;
- a brown-out release is only ever preceded by a good supply;
- the counter freezes while the oscillator is down and never passes its limit;
- a cause bit being set survives a clear;
- the boot pulse only appears together with a release.

Other behaviours need the bench's scenarios:
- the exact release cycle for each source;
- the delay added by oscillator gaps;
- the restart of a partial count;
- a flash flag that arrives late;
- a supply that recovers late;
- a power-on that wipes the other cause bits.

// File: rtl/chip_reset_pkg.sv
// Shared types and cause bit positions for the reset sequencer.
package chip_reset_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // reset released, chip running
        ST_HOLD = 2'd1,   // a request is present
        ST_WAIT = 2'd2    // requests gone, waiting on count and flags
    } seq_state_t;

    localparam int CAUSE_W   = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_BOD = 3;
endpackage

// File: rtl/rst_wake_counter.sv
// Wake-up counter. It clears on request, advances when enabled and
// saturates at WAKE_CYCLES.
// Assumes: clr has priority over adv; rst_n is synchronous, active low.
module rst_wake_counter #(
    parameter int WAKE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic done
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAKE_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Count enabled cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag a finished count.
    always_comb done = (cnt == LIMIT);

    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(cnt));
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
endmodule

// File: rtl/rst_cause_reg.sv
// Sticky reset-cause register. Power-on loads only the power-on bit.
// Requests set bits, and masked software writes clear bits.
// Assumes: a set wins over a clear in the same cycle.
module rst_cause_reg
    import chip_reset_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr_we,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] clr_eff;

    // Apply the clear mask only while the write strobe is high.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Hold, clear and set the cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= CAUSE_W'(1) << CAUSE_POR;
        end else begin
            cause <= (cause & ~clr_eff) | set_vec;
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/rst_seq_fsm.sv
// Release state machine: hold, wait, run. It drives the registered reset
// outputs and the boot pulse, and it remembers brown-out involvement.
// Assumes: inputs synchronous to clk; rst_n is the power-on request.
module rst_seq_fsm
    import chip_reset_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_req,
    input  logic ext_rst_n,
    input  logic bod_req,
    input  logic vdd_ok,
    input  logic osc_ready,
    input  logic flash_init_done,
    input  logic cnt_done,
    output logic cnt_clr,
    output logic cnt_adv,
    output logic sys_rst,
    output logic rst_out_n,
    output logic boot_go
);
    seq_state_t state;
    logic       bod_seen;
    logic       release_ok;

    // Decide release and drive the counter controls.
    always_comb begin
        release_ok = (state == ST_WAIT) && cnt_done && osc_ready &&
                     flash_init_done && (!bod_seen || vdd_ok);
        cnt_clr    = any_req || (state != ST_WAIT);
        cnt_adv    = osc_ready;
    end

    // State, registered reset outputs and brown-out memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HOLD;
            sys_rst   <= 1'b1;
            rst_out_n <= 1'b0;
            bod_seen  <= 1'b0;
            boot_go   <= 1'b0;
        end else if (any_req) begin
            state     <= ST_HOLD;
            sys_rst   <= 1'b1;
            rst_out_n <= 1'b0;
            bod_seen  <= bod_seen | bod_req;
            boot_go   <= 1'b0;
        end else begin
            boot_go <= 1'b0;
            case (state)
                ST_HOLD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (release_ok) begin
                        state     <= ST_RUN;
                        sys_rst   <= 1'b0;
                        rst_out_n <= 1'b1;
                        bod_seen  <= 1'b0;
                        boot_go   <= 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assert_req_forces_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (sys_rst && !rst_out_n));
    assert_release_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> $past(ext_rst_n && osc_ready && flash_init_done && cnt_done));
    assert_bod_vdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst) && $past(bod_seen)) |-> $past(vdd_ok));
    assert_boot_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_go |-> $fell(sys_rst));
endmodule

// File: rtl/chip_reset_seq.sv
// Top of the reset sequencer. It merges power-on, pin, watchdog and
// brown-out requests and releases reset once the count and readiness
// flags allow it.
// Assumes: all inputs are already synchronised to clk.
module chip_reset_seq
    import chip_reset_pkg::*;
#(
    parameter int          WAKE_CYCLES  = 256,
    parameter int          ADDR_W       = 32,
    parameter logic [31:0] RESET_VECTOR = 32'h0
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic               wdt_req,
    input  logic               bod_req,
    input  logic               vdd_ok,
    input  logic               osc_ready,
    input  logic               flash_init_done,
    input  logic               cause_clr_we,
    input  logic [CAUSE_W-1:0] cause_clr_mask,
    output logic               sys_rst,
    output logic               rst_out_n,
    output logic               boot_go,
    output logic [ADDR_W-1:0]  boot_addr,
    output logic [CAUSE_W-1:0] cause
);
    logic               any_req;
    logic [CAUSE_W-1:0] set_vec;
    logic               cnt_clr;
    logic               cnt_adv;
    logic               cnt_done;

    // Merge the running-time requests and form the cause set vector.
    always_comb begin
        any_req            = !ext_rst_n || wdt_req || bod_req;
        set_vec            = '0;
        set_vec[CAUSE_EXT] = !ext_rst_n;
        set_vec[CAUSE_WDT] = wdt_req;
        set_vec[CAUSE_BOD] = bod_req;
    end

    // Present the reset vector to the core fetch path.
    always_comb boot_addr = ADDR_W'(RESET_VECTOR);

    rst_wake_counter #(.WAKE_CYCLES(WAKE_CYCLES)) u_cnt (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (cnt_clr),
        .adv   (cnt_adv),
        .done  (cnt_done)
    );

    rst_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (por_n),
        .any_req         (any_req),
        .ext_rst_n       (ext_rst_n),
        .bod_req         (bod_req),
        .vdd_ok          (vdd_ok),
        .osc_ready       (osc_ready),
        .flash_init_done (flash_init_done),
        .cnt_done        (cnt_done),
        .cnt_clr         (cnt_clr),
        .cnt_adv         (cnt_adv),
        .sys_rst         (sys_rst),
        .rst_out_n       (rst_out_n),
        .boot_go         (boot_go)
    );

    rst_cause_reg u_cause (
        .clk      (clk),
        .rst_n    (por_n),
        .set_vec  (set_vec),
        .clr_we   (cause_clr_we),
        .clr_mask (cause_clr_mask),
        .cause    (cause)
    );
endmodule

// File: tb/chip_reset_seq_bench.sv
module chip_reset_seq_bench;
    localparam int N = 256;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_req = 1'b0;
    logic       bod_req = 1'b0;
    logic       vdd_ok = 1'b1;
    logic       osc_ready = 1'b1;
    logic       flash_init_done = 1'b1;
    logic       cause_clr_we = 1'b0;
    logic [3:0] cause_clr_mask = 4'h0;
    logic        sys_rst, rst_out_n, boot_go;
    logic [31:0] boot_addr;
    logic [3:0]  cause;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    chip_reset_seq #(.WAKE_CYCLES(N)) u_chip_reset_seq (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_req(wdt_req),
        .bod_req(bod_req), .vdd_ok(vdd_ok), .osc_ready(osc_ready),
        .flash_init_done(flash_init_done), .cause_clr_we(cause_clr_we),
        .cause_clr_mask(cause_clr_mask), .sys_rst(sys_rst), .rst_out_n(rst_out_n),
        .boot_go(boot_go), .boot_addr(boot_addr), .cause(cause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until release; check the boot pulse (R9) on the way out.
    task automatic measure(input int exp, input string req);
        int n = 0;
        while (sys_rst && n < N + 50) begin
            @(posedge clk); @(negedge clk); n++;
        end
        check(n == exp, req, n, exp);
        check(rst_out_n == 1'b1, req, rst_out_n, 1);
        check(boot_go == 1'b1 && boot_addr == 32'h0, "R9", boot_go, 1);
        edges(1);
        check(boot_go == 1'b0, "R9", boot_go, 0);
    endtask

    task automatic pulse_ext(input int len);
        ext_rst_n = 1'b0;
        edges(len);
        check(sys_rst == 1'b1 && rst_out_n == 1'b0, "R2", sys_rst, 1);
        ext_rst_n = 1'b1;
    endtask

    task automatic t_por;
        edges(3);
        check(sys_rst == 1'b1 && rst_out_n == 1'b0, "R1", sys_rst, 1);
        check(cause == 4'b0001, "R1", cause, 1);
        por_n = 1'b1;
        measure(N + 2, "R4");
    endtask

    task automatic t_ext;
        ext_rst_n = 1'b0;
        edges(N + 10);
        check(sys_rst == 1'b1, "R3", sys_rst, 1);
        ext_rst_n = 1'b1;
        measure(N + 2, "R4");
        check(cause == 4'b0011, "R8", cause, 3);
    endtask

    task automatic t_wdt_osc;
        osc_ready = 1'b0;
        wdt_req = 1'b1;
        edges(1);
        check(sys_rst == 1'b1 && rst_out_n == 1'b0, "R2", sys_rst, 1);
        wdt_req = 1'b0;
        edges(N + 10);
        check(sys_rst == 1'b1, "R3", sys_rst, 1);
        osc_ready = 1'b1;
        measure(N + 1, "R4");
        check(cause[2] == 1'b1, "R8", cause, 4'b0111);
    endtask

    task automatic t_late_flash;
        flash_init_done = 1'b0;
        pulse_ext(2);
        edges(N + 12);
        check(sys_rst == 1'b1, "R5", sys_rst, 1);
        flash_init_done = 1'b1;
        measure(1, "R5");
    endtask

    task automatic t_bod;
        vdd_ok = 1'b0;
        bod_req = 1'b1;
        edges(3);
        check(sys_rst == 1'b1 && rst_out_n == 1'b0, "R2", sys_rst, 1);
        bod_req = 1'b0;
        edges(N + 12);
        check(sys_rst == 1'b1, "R6", sys_rst, 1);
        check(cause[3] == 1'b1, "R8", cause, 8);
        vdd_ok = 1'b1;
        measure(1, "R6");
    endtask

    task automatic t_restart;
        pulse_ext(1);
        edges(100);
        check(sys_rst == 1'b1, "R7", sys_rst, 1);
        wdt_req = 1'b1;
        edges(1);
        wdt_req = 1'b0;
        measure(N + 2, "R7");
    endtask

    task automatic t_overlap;
        ext_rst_n = 1'b0;
        wdt_req = 1'b1;
        edges(2);
        ext_rst_n = 1'b1;
        edges(5);
        check(sys_rst == 1'b1, "R2", sys_rst, 1);
        wdt_req = 1'b0;
        measure(N + 2, "R7");
    endtask

    task automatic t_cause;
        cause_clr_we = 1'b1;
        cause_clr_mask = 4'hF;
        edges(1);
        cause_clr_we = 1'b0;
        check(cause == 4'b0000, "R8", cause, 0);
        wdt_req = 1'b1;
        cause_clr_we = 1'b1;
        cause_clr_mask = 4'b0100;
        edges(1);
        cause_clr_we = 1'b0;
        wdt_req = 1'b0;
        check(cause == 4'b0100, "R8", cause, 4);
        measure(N + 2, "R4");
        pulse_ext(1);
        edges(2);
        check(cause == 4'b0110, "R8", cause, 6);
        por_n = 1'b0;
        edges(1);
        check(cause == 4'b0001 && sys_rst == 1'b1, "R1", cause, 1);
        por_n = 1'b1;
        measure(N + 2, "R4");
    endtask

    initial begin
        @(negedge clk);
        t_por();
        t_ext();
        t_wdt_osc();
        t_late_flash();
        t_bod();
        t_restart();
        t_overlap();
        t_cause();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule